// File: doc/BRIEF.md
# Address-Window Memory Access Trace Monitor

This block watches a simple memory request/response interface without disturbing it. For every access whose address lies inside one of a set of programmable address windows, it builds one trace record that holds the direction, the address, the size in bytes and the data word. Records are offered on a valid/ready output stream.

A write is recorded in the cycle its request is issued, using the write data. A read is recorded only when its response returns, so the record carries the value that was read. Reads may be outstanding several deep, and responses return in request order. The window decision for a read is made when its request is seen. The decision is then kept with the pending read until its response arrives.

Windows are loaded through a small configuration port. The port takes a window index, a lower bound and an upper bound. A separate count sets how many windows, starting from index 0, take part in matching. That count resets to zero, so nothing is traced until software enables windows. A stalled output stream and illegal access sizes are reported through two sticky flags.

Top module: `mtrace_mon`

## Requirements
- R1: After reset, rec_valid_o, overflow_o and len_err_o are 0 and the active window count is 0, so no access produces a record until the count is written.
- R2: A window matches an address when lower bound <= address <= upper bound; both bounds are inclusive, and the addresses one below the lower bound and one above the upper bound do not match.
- R3: Only windows whose index is below the active window count take part in matching.
- R4: A matching write request (req_write_i=1) produces a record with rec_write_o=1, the request address, the byte count and req_wdata_i, with rec_valid_o high on the clock edge after the request.
- R5: A matching read produces a record with rec_write_o=0 on the clock edge after its response, carrying rsp_rdata_i. Responses pair with reads in request order, and a response whose read did not match is consumed without a record.
- R6: An access yields at most one record, even when several active windows contain its address.
- R7: req_len_i encodes the size: 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes, and rec_bytes_o gives the byte count. Code 2'b11 produces no record and sets the sticky len_err_o.
- R8: A record is held unchanged while rec_valid_o=1 and rec_ready_i=0. A matching access that arrives while the holding register is full and not draining in that cycle is dropped and sets the sticky overflow_o.
- R9: A write of the active window count is ignored unless the monitor is idle. Idle means no record is held, no read is outstanding, and no request or response is present in that cycle.
- R10: At reset, window 0 spans 0x0000_0000 to 0x0FFF_FFFF, and the other windows match no address.
- R11: When a matching read response and a matching write request arrive in the same cycle, the read record is kept, and the write record is dropped with overflow_o set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_win_we_i | input | 1 | Write one window's bounds |
| cfg_win_idx_i | input | IDX_W | Window index to write |
| cfg_win_lo_i | input | AW | Inclusive lower bound |
| cfg_win_hi_i | input | AW | Inclusive upper bound |
| cfg_cnt_we_i | input | 1 | Write the active window count |
| cfg_cnt_i | input | CNT_W | Active window count |
| req_valid_i | input | 1 | Memory request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_len_i | input | 2 | Size code (see R7) |
| req_wdata_i | input | DW | Write data |
| rsp_valid_i | input | 1 | Read response present |
| rsp_rdata_i | input | DW | Read response data |
| rec_valid_o | output | 1 | Trace record available |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_write_o | output | 1 | Record direction, 1 = write |
| rec_addr_o | output | AW | Record address |
| rec_bytes_o | output | 3 | Record size in bytes |
| rec_data_o | output | DW | Record data |
| overflow_o | output | 1 | Sticky: a record was dropped |
| len_err_o | output | 1 | Sticky: an illegal size code was seen |

## Verification
The bench probes both edges of each window and one address beyond each edge. A design with strict or off-by-one comparisons would then lose or add records. It sends accesses into overlapping windows and confirms that exactly one record follows. An OR of records per window would show a second valid cycle. It leaves several reads outstanding with a non-matching read in the middle. This exposes pairing that slips by one response and shows up as wrong data on a record. It also stalls the output and collides a read response with a write request. A design that overwrote the held record, lost the read, or missed the overflow flag would be caught there, and so would one that accepted a count change while busy.

// File: rtl/mtrace_pkg.sv
package mtrace_pkg;

  typedef enum logic [1:0] {
    LEN_B1  = 2'b00,
    LEN_B2  = 2'b01,
    LEN_B4  = 2'b10,
    LEN_BAD = 2'b11
  } len_code_e;

  function automatic logic len_legal(input logic [1:0] code);
    return code != LEN_BAD;
  endfunction

  function automatic logic [2:0] len_bytes(input logic [1:0] code);
    case (code)
      LEN_B1:  return 3'd1;
      LEN_B2:  return 3'd2;
      LEN_B4:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/mtrace_win_match.sv
module mtrace_win_match #(
  parameter int          AW      = 32,
  parameter int          MAX_WIN = 10,
  parameter int          IDX_W   = 4,
  parameter int          CNT_W   = 4,
  parameter logic [AW-1:0] DEF_LO = '0,
  parameter logic [AW-1:0] DEF_HI = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_we_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic [AW-1:0]    win_lo_i,
  input  logic [AW-1:0]    win_hi_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             idle_i,
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o
);

  logic [CNT_W-1:0]   cnt_q;
  logic [MAX_WIN-1:0] win_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_we_i && idle_i) cnt_q <= cnt_i;
  end

  for (genvar g = 0; g < MAX_WIN; g++) begin : g_win
    logic [AW-1:0] lo_q, hi_q;
    localparam logic [AW-1:0] RST_LO = (g == 0) ? DEF_LO : '1;
    localparam logic [AW-1:0] RST_HI = (g == 0) ? DEF_HI : '0;
    logic sel;
    assign sel = win_we_i && (win_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= RST_LO;
        hi_q <= RST_HI;
      end else if (sel) begin
        lo_q <= win_lo_i;
        hi_q <= win_hi_i;
      end
    end

    // inclusive on both ends
    assign win_hit[g] = (CNT_W'(g) < cnt_q) && (addr_i >= lo_q) && (addr_i <= hi_q);
  end

  assign hit_o = |win_hit;

  p_cnt_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && !idle_i) |=> $stable(cnt_q));

  p_hit_needs_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (cnt_q != '0));

endmodule

// File: rtl/mtrace_rd_track.sv
module mtrace_rd_track #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_hit_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [1:0]    push_len_i,
  input  logic          pop_i,
  output logic          head_hit_o,
  output logic [AW-1:0] head_addr_o,
  output logic [1:0]    head_len_o,
  output logic          empty_o,
  output logic          full_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [1:0]       len_q  [DEPTH];
  logic [DEPTH-1:0] hit_q;
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      len_q[wr_ptr_q]  <= push_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) begin
        hit_q[wr_ptr_q] <= push_hit_i;
        wr_ptr_q        <= step(wr_ptr_q);
      end
      if (do_pop) rd_ptr_q <= step(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_hit_o  = hit_q[rd_ptr_q];
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_len_o  = len_q[rd_ptr_q];

  p_no_push_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));

  p_no_pop_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/mtrace_rec_out.sv
module mtrace_rec_out #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          drop_i,
  input  logic          ld_write_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [2:0]    ld_bytes_i,
  input  logic [DW-1:0] ld_data_i,
  output logic          rec_valid_o,
  input  logic          rec_ready_i,
  output logic          rec_write_o,
  output logic [AW-1:0] rec_addr_o,
  output logic [2:0]    rec_bytes_o,
  output logic [DW-1:0] rec_data_o,
  output logic          overflow_o
);

  logic slot_free;
  assign slot_free = !rec_valid_o || rec_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_valid_o <= 1'b0;
      rec_write_o <= 1'b0;
      rec_addr_o  <= '0;
      rec_bytes_o <= '0;
      rec_data_o  <= '0;
      overflow_o  <= 1'b0;
    end else begin
      if (load_i && slot_free) begin
        rec_valid_o <= 1'b1;
        rec_write_o <= ld_write_i;
        rec_addr_o  <= ld_addr_i;
        rec_bytes_o <= ld_bytes_i;
        rec_data_o  <= ld_data_i;
      end else if (rec_ready_i) begin
        rec_valid_o <= 1'b0;
      end
      if ((load_i && !slot_free) || drop_i) overflow_o <= 1'b1;
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_addr_o)
      && $stable(rec_data_o) && $stable(rec_write_o) && $stable(rec_bytes_o)));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

endmodule

// File: rtl/mtrace_mon.sv
module mtrace_mon
  import mtrace_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int MAX_WIN  = 10,
  parameter int RD_DEPTH = 4,
  parameter logic [AW-1:0] DEF_LO = 32'h0000_0000,
  parameter logic [AW-1:0] DEF_HI = 32'h0FFF_FFFF,
  localparam int IDX_W = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1,
  localparam int CNT_W = $clog2(MAX_WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_win_we_i,
  input  logic [IDX_W-1:0] cfg_win_idx_i,
  input  logic [AW-1:0]    cfg_win_lo_i,
  input  logic [AW-1:0]    cfg_win_hi_i,
  input  logic             cfg_cnt_we_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [1:0]       req_len_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             rsp_valid_i,
  input  logic [DW-1:0]    rsp_rdata_i,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic             rec_write_o,
  output logic [AW-1:0]    rec_addr_o,
  output logic [2:0]       rec_bytes_o,
  output logic [DW-1:0]    rec_data_o,
  output logic             overflow_o,
  output logic             len_err_o
);

  logic          win_hit, len_ok, idle;
  logic          trk_hit, trk_empty, trk_full;
  logic [AW-1:0] trk_addr;
  logic [1:0]    trk_len;
  logic          wr_cand, rd_cand;
  logic          ld_write;
  logic [AW-1:0] ld_addr;
  logic [2:0]    ld_bytes;
  logic [DW-1:0] ld_data;

  assign len_ok = len_legal(req_len_i);
  assign idle   = !rec_valid_o && trk_empty && !req_valid_i && !rsp_valid_i;

  mtrace_win_match #(
    .AW(AW), .MAX_WIN(MAX_WIN), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
  ) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_we_i  (cfg_win_we_i),
    .win_idx_i (cfg_win_idx_i),
    .win_lo_i  (cfg_win_lo_i),
    .win_hi_i  (cfg_win_hi_i),
    .cnt_we_i  (cfg_cnt_we_i),
    .cnt_i     (cfg_cnt_i),
    .idle_i    (idle),
    .addr_i    (req_addr_i),
    .hit_o     (win_hit)
  );

  // read filter decision is made at request time and queued with the read
  mtrace_rd_track #(.AW(AW), .DEPTH(RD_DEPTH)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (req_valid_i && !req_write_i),
    .push_hit_i  (win_hit && len_ok),
    .push_addr_i (req_addr_i),
    .push_len_i  (req_len_i),
    .pop_i       (rsp_valid_i),
    .head_hit_o  (trk_hit),
    .head_addr_o (trk_addr),
    .head_len_o  (trk_len),
    .empty_o     (trk_empty),
    .full_o      (trk_full)
  );

  assign wr_cand = req_valid_i && req_write_i && len_ok && win_hit;
  assign rd_cand = rsp_valid_i && !trk_empty && trk_hit;

  // older access (read response) takes the slot on a collision
  always_comb begin
    if (rd_cand) begin
      ld_write = 1'b0;
      ld_addr  = trk_addr;
      ld_bytes = len_bytes(trk_len);
      ld_data  = rsp_rdata_i;
    end else begin
      ld_write = 1'b1;
      ld_addr  = req_addr_i;
      ld_bytes = len_bytes(req_len_i);
      ld_data  = req_wdata_i;
    end
  end

  mtrace_rec_out #(.AW(AW), .DW(DW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (rd_cand || wr_cand),
    .drop_i      (rd_cand && wr_cand),
    .ld_write_i  (ld_write),
    .ld_addr_i   (ld_addr),
    .ld_bytes_i  (ld_bytes),
    .ld_data_i   (ld_data),
    .rec_valid_o (rec_valid_o),
    .rec_ready_i (rec_ready_i),
    .rec_write_o (rec_write_o),
    .rec_addr_o  (rec_addr_o),
    .rec_bytes_o (rec_bytes_o),
    .rec_data_o  (rec_data_o),
    .overflow_o  (overflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          len_err_o <= 1'b0;
    else if (req_valid_i && !len_ok)      len_err_o <= 1'b1;
  end

  p_bytes_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_bytes_o == 3'd1 || rec_bytes_o == 3'd2 || rec_bytes_o == 3'd4));

  p_len_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |=> len_err_o);

  p_bad_len_no_rec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !len_ok && !rsp_valid_i && !rec_valid_o) |=> !rec_valid_o);

  p_write_rec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cand && !rsp_valid_i && (!rec_valid_o || rec_ready_i)) |=> (rec_valid_o && rec_write_o));

  p_resp_needs_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> !trk_empty);

  p_read_room_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |-> (!trk_full || rsp_valid_i));

endmodule

// File: tb/mtrace_mon_bench.sv
module mtrace_mon_bench;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_win_we = 1'b0;
  logic [3:0]    cfg_win_idx = '0;
  logic [AW-1:0] cfg_win_lo = '0, cfg_win_hi = '0;
  logic          cfg_cnt_we = 1'b0;
  logic [3:0]    cfg_cnt = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_rdata = '0;
  logic          rec_ready = 1'b1;
  logic          rec_valid_o, rec_write_o, overflow_o, len_err_o;
  logic [AW-1:0] rec_addr_o;
  logic [2:0]    rec_bytes_o;
  logic [DW-1:0] rec_data_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  mtrace_mon u_mtrace_mon (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_win_we_i(cfg_win_we), .cfg_win_idx_i(cfg_win_idx),
    .cfg_win_lo_i(cfg_win_lo), .cfg_win_hi_i(cfg_win_hi),
    .cfg_cnt_we_i(cfg_cnt_we), .cfg_cnt_i(cfg_cnt),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_wdata_i(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready), .rec_write_o(rec_write_o),
    .rec_addr_o(rec_addr_o), .rec_bytes_o(rec_bytes_o), .rec_data_o(rec_data_o),
    .overflow_o(overflow_o), .len_err_o(len_err_o)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  len;
    logic [31:0] addr;
    logic [31:0] data;
    logic        hit;
  } vec_t;

  // windows: w0 0x1000..0x1FFF, w1 0x1800..0x27FF (overlap), w2 0x80000000..0x80000003
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b10, 32'h0000_1000, 32'hA5A5_0001, 1'b1},  // R2 lower edge
    '{1'b1, 2'b10, 32'h0000_0FFF, 32'hA5A5_0002, 1'b0},  // R2 below
    '{1'b0, 2'b00, 32'h0000_1FFF, 32'h0000_00C3, 1'b1},  // R6 overlap, R2 upper w0
    '{1'b0, 2'b10, 32'h0000_2800, 32'h1234_5678, 1'b0},  // R2 above w1
    '{1'b1, 2'b01, 32'h0000_27FF, 32'h0000_BEEF, 1'b1},  // R2 upper w1
    '{1'b0, 2'b10, 32'h8000_0003, 32'hDEAD_BEEF, 1'b1},  // R5 read data
    '{1'b1, 2'b00, 32'h8000_0004, 32'h0000_0011, 1'b0},  // R2 above w2
    '{1'b0, 2'b01, 32'h0000_1800, 32'h0000_7E57, 1'b1}   // R6 overlap
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_win(input int idx, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    cfg_win_we = 1'b1; cfg_win_idx = 4'(idx); cfg_win_lo = lo; cfg_win_hi = hi;
    @(negedge clk);
    cfg_win_we = 1'b0;
  endtask

  task automatic set_cnt(input int c);
    @(negedge clk);
    cfg_cnt_we = 1'b1; cfg_cnt = 4'(c);
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  function automatic logic [2:0] exp_bytes(input logic [1:0] len);
    return 3'd1 << len;
  endfunction

  // issue one access, check record one edge after request (write) or response (read)
  task automatic access(input logic wr, input logic [1:0] len, input logic [31:0] addr,
                        input logic [31:0] data, input logic hit, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      rsp_valid = 1'b1; rsp_rdata = data;
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    chk({tag, " valid"}, 64'(rec_valid_o), 64'(hit));
    if (hit) begin
      chk({tag, " dir"},   64'(rec_write_o), 64'(wr));
      chk({tag, " addr"},  64'(rec_addr_o), 64'(addr));
      chk({tag, " bytes"}, 64'(rec_bytes_o), 64'(exp_bytes(len)));
      chk({tag, " data"},  64'(rec_data_o), 64'(data));
      @(negedge clk);
      chk({tag, " single record R6"}, 64'(rec_valid_o), 64'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 rec_valid", 64'(rec_valid_o), 64'd0);
    chk("R1 overflow", 64'(overflow_o), 64'd0);
    chk("R1 len_err", 64'(len_err_o), 64'd0);
    // R1 count 0: access inside default window 0 gives no record
    access(1'b1, 2'b10, 32'h0000_0100, 32'h1111_1111, 1'b0, "R1 no trace before count");

    // R10 default window 0 after enabling one window
    set_cnt(1);
    access(1'b1, 2'b10, 32'h0FFF_FFFF, 32'h2222_2222, 1'b1, "R10 default upper");
    access(1'b1, 2'b10, 32'h1000_0000, 32'h3333_3333, 1'b0, "R10 past default");
    access(1'b0, 2'b00, 32'h0000_0000, 32'h0000_0044, 1'b1, "R10 default lower");

    // table walk
    set_win(0, 32'h0000_1000, 32'h0000_1FFF);
    set_win(1, 32'h0000_1800, 32'h0000_27FF);
    set_win(2, 32'h8000_0000, 32'h8000_0003);
    set_cnt(3);
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].len, VECS[i].addr, VECS[i].data, VECS[i].hit,
             VECS[i].wr ? "R4 R2 table" : "R5 R2 table");
    end

    // R3 window 1 excluded when count is 1
    set_cnt(1);
    access(1'b1, 2'b10, 32'h0000_2000, 32'h4444_4444, 1'b0, "R3 inactive window");
    set_cnt(3);
    access(1'b1, 2'b10, 32'h0000_2000, 32'h5555_5555, 1'b1, "R3 active window");

    // R7 illegal size code
    chk("R7 len_err before", 64'(len_err_o), 64'd0);
    access(1'b1, 2'b11, 32'h0000_1004, 32'h6666_6666, 1'b0, "R7 bad write");
    chk("R7 len_err set", 64'(len_err_o), 64'd1);
    access(1'b0, 2'b11, 32'h0000_1008, 32'h7777_7777, 1'b0, "R7 bad read");
    access(1'b1, 2'b00, 32'h0000_1009, 32'h0000_0099, 1'b1, "R7 one byte after error");
    chk("R7 len_err sticky", 64'(len_err_o), 64'd1);

    // R5 three outstanding reads, middle one misses
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_len = 2'b10; req_addr = 32'h0000_1100;
    @(negedge clk);
    req_addr = 32'h0000_0500;
    @(negedge clk);
    req_addr = 32'h0000_1804;
    @(negedge clk);
    req_valid = 1'b0;
    rsp_valid = 1'b1; rsp_rdata = 32'hAAAA_0001;
    @(negedge clk);
    chk("R5 order first valid", 64'(rec_valid_o), 64'd1);
    chk("R5 order first addr", 64'(rec_addr_o), 64'h1100);
    chk("R5 order first data", 64'(rec_data_o), 64'hAAAA_0001);
    rsp_rdata = 32'hAAAA_0002;
    @(negedge clk);
    chk("R5 miss consumed", 64'(rec_valid_o), 64'd0);
    rsp_rdata = 32'hAAAA_0003;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R5 order third addr", 64'(rec_addr_o), 64'h1804);
    chk("R5 order third data", 64'(rec_data_o), 64'hAAAA_0003);
    chk("R5 order third dir", 64'(rec_write_o), 64'd0);

    // R11 read response and write request collide
    chk("R11 overflow before", 64'(overflow_o), 64'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_len = 2'b10; req_addr = 32'h0000_1200;
    @(negedge clk);
    req_write = 1'b1; req_addr = 32'h0000_1300; req_wdata = 32'hBBBB_BBBB;
    rsp_valid = 1'b1; rsp_rdata = 32'hCCCC_CCCC;
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
    chk("R11 kept read dir", 64'(rec_write_o), 64'd0);
    chk("R11 kept read addr", 64'(rec_addr_o), 64'h1200);
    chk("R11 kept read data", 64'(rec_data_o), 64'hCCCC_CCCC);
    chk("R11 overflow", 64'(overflow_o), 64'd1);
    @(negedge clk);
    chk("R11 write dropped", 64'(rec_valid_o), 64'd0);

    // R8 stall behaviour after fresh reset
    do_reset();
    chk("R1 overflow after reset", 64'(overflow_o), 64'd0);
    set_win(0, 32'h0000_1000, 32'h0000_1FFF);
    set_cnt(1);
    rec_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_len = 2'b10; req_addr = 32'h0000_1010;
    req_wdata = 32'hD1D1_D1D1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 held valid", 64'(rec_valid_o), 64'd1);
    chk("R8 held data", 64'(rec_data_o), 64'hD1D1_D1D1);
    chk("R8 no overflow yet", 64'(overflow_o), 64'd0);
    req_valid = 1'b1; req_addr = 32'h0000_1020; req_wdata = 32'hD2D2_D2D2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 overflow set", 64'(overflow_o), 64'd1);
    chk("R8 held addr kept", 64'(rec_addr_o), 64'h1010);
    chk("R8 held data kept", 64'(rec_data_o), 64'hD1D1_D1D1);

    // R9 count write while busy is ignored
    cfg_cnt_we = 1'b1; cfg_cnt = 4'd0;
    @(negedge clk);
    cfg_cnt_we = 1'b0;
    rec_ready = 1'b1;
    @(negedge clk);
    chk("R8 drained", 64'(rec_valid_o), 64'd0);
    access(1'b1, 2'b01, 32'h0000_1030, 32'h0000_9999, 1'b1, "R9 count unchanged");
    chk("R8 overflow sticky", 64'(overflow_o), 64'd1);
    set_cnt(0);
    access(1'b1, 2'b01, 32'h0000_1040, 32'h0000_8888, 1'b0, "R9 idle count write");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule